// File: doc/BRIEF.md
# Sound-Chip Register Access Sequencer

This block lets a host read and write the registers of an external sound generator. The generator has no direct bus connection. Its 8-bit data lines sit on data port A of a general-purpose parallel I/O port. Its two bus-control lines are bits 7:6 of control port C. The host hands over one request: read or write, a register number, write data, and a 6-bit shadow of the other port C bits. The sequencer then turns the request into a chain of single-cycle register writes on the parallel port's local bus. It returns read data with a one-cycle done pulse.

A read needs port A turned around to input and back again. On the parallel port, every configure write clears all output latches. After each configure write the sequencer therefore rewrites port C at once. That rewrite carries an idle bus function and the host's low bits: keyboard row 3:0, cassette motor 4 and cassette output 5. Each active bus function is held for a programmable number of cycles. Between two active functions the bus always returns to idle.

Top module: `sndbus_seq`

## Requirements
- R1: While reset is active and after release with no request, `busy`, `done`, `pp_wr` and `pp_rd` are low, and nothing is written or read on the parallel port while `busy` is low.
- R2: A request (`req_valid` high while `busy` is low) is taken at that clock edge and `busy` is high in the next cycle. `busy` stays high until the cycle in which `done` pulses for exactly one cycle with `busy` low.
- R3: A request presented while `busy` is high is ignored: it produces no port activity, no register change in the sound chip and no extra `done`.
- R4: Port addresses are 0 = data port A, 1 = port B, 2 = control port C, 3 = configure. The function field is `pp_wdata[7:6]` of a port C write: 00 idle, 01 read selected register, 10 write selected register, 11 latch register number. A write request issues exactly these port writes, in this order:
  - (0, register), (2, 11), (2, 00), (0, data), (2, 10), (2, 00).
- R5: A read request issues exactly these port writes, in this order:
  - (0, register), (2, 11), (2, 00), (3, 92h), (2, 00), (2, 01), (2, 00), (3, 82h), (2, 00).
  - A port A read strobe lies between the 01 write and the following 00 write.
- R6: Every port C write carries in bits 5:0 the `ctl_shadow` value captured when the request was taken.
- R7: Every configure write is followed in the very next cycle by a port C write.
- R8: Functions 11 and 10 remain in the port C latch for `hold_len`+1 cycles, and function 01 for `hold_len`+2 cycles. An active function is always followed by 00. A write request keeps `busy` high for 2·`hold_len`+6 cycles and a read request for 2·`hold_len`+10 cycles.
- R9: After a read, `rd_data` holds the byte the port returned on port A while function 01 was active. It stays valid from `done` until the next read completes; a write request leaves it unchanged.
- R10: When `done` pulses, the port is configured 82h (port A output) and the port C latch holds function 00 with the captured shadow bits.
- R11: `pp_rd` is asserted only with address 0, never together with `pp_wr`, and only while port A is configured as input and function 01 is in the latch.
- R12: Keyboard scanning: a read of register 0Eh returns the matrix byte for the row carried in shadow bits 3:0.
- R13: Configure writes carry only the values 82h or 92h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_len | input | HOLD_W | Extra cycles each active bus function is held |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_reg | input | 8 | Sound-chip register number |
| req_wdata | input | 8 | Data for a register write |
| ctl_shadow | input | 6 | Host-held port C bits 5:0 (row, motor, cassette out) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Data returned by the last read |
| pp_wr | output | 1 | Parallel-port register write strobe |
| pp_rd | output | 1 | Parallel-port register read strobe |
| pp_addr | output | 2 | Parallel-port register address |
| pp_wdata | output | 8 | Parallel-port write data |
| pp_rdata | input | 8 | Parallel-port read data |

## Verification
The assertions assume the following about the inputs:
- `hold_len` does not change while `busy` is high.
- `ctl_shadow` is sampled only at request acceptance, so the shadow check compares against that captured value.
- `pp_rdata` is valid in the same cycle as `pp_rd`.

The stimulus keeps to these rules. It changes the hold length only between requests and uses lengths 0, 2 and 5. Its port model answers port A reads combinationally from the selected register. One request deliberately changes the request fields and the shadow while busy, which checks that the captured values, not the live ones, are used.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;

    localparam int BYTE_W = 8;
    localparam int FN_W   = 2;
    localparam int SH_W   = BYTE_W - FN_W;

    // parallel-port register addresses
    localparam logic [1:0] PORT_DATA = 2'd0;
    localparam logic [1:0] PORT_CTRL = 2'd2;
    localparam logic [1:0] PORT_CFG  = 2'd3;

    // configure words: data port as output / as input, others fixed
    localparam logic [BYTE_W-1:0] CFG_DATA_OUT = 8'h82;
    localparam logic [BYTE_W-1:0] CFG_DATA_IN  = 8'h92;

    typedef enum logic [FN_W-1:0] {
        FN_IDLE  = 2'b00,
        FN_READ  = 2'b01,
        FN_WRITE = 2'b10,
        FN_LATCH = 2'b11
    } bus_fn_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL_A,
        ST_SEL_FN,
        ST_SEL_OFF,
        ST_DAT_A,
        ST_DAT_FN,
        ST_DAT_OFF,
        ST_CFG_IN,
        ST_CFG_IN_C,
        ST_RD_FN,
        ST_RD_CAP,
        ST_RD_OFF,
        ST_CFG_OUT,
        ST_CFG_OUT_C
    } step_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              timed;
        logic [1:0]        addr;
        logic [BYTE_W-1:0] data;
    } port_op_t;

    typedef struct packed {
        step_e             step;
        logic              is_wr;
        logic [BYTE_W-1:0] rg;
        logic [BYTE_W-1:0] wd;
        logic [SH_W-1:0]   sh;
        logic [BYTE_W-1:0] rdat;
        logic              done;
    } seq_state_t;

endpackage

// File: rtl/sndbus_hold_timer.sv
module sndbus_hold_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         first,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    assign first   = (cnt_q == '0);
    assign expired = (cnt_q == limit);

    always_comb begin
        if (run && !expired) cnt_d = cnt_q + 1'b1;
        else                 cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sndbus_step_decode.sv
module sndbus_step_decode
    import sndbus_pkg::*;
(
    input  step_e             step,
    input  logic [BYTE_W-1:0] rg,
    input  logic [BYTE_W-1:0] wd,
    input  logic [SH_W-1:0]   sh,
    output port_op_t          op
);

    function automatic logic [BYTE_W-1:0] ctrl_word(input bus_fn_e fn,
                                                    input logic [SH_W-1:0] bits);
        return {fn, bits};
    endfunction

    always_comb begin
        op = '{wr: 1'b0, rd: 1'b0, timed: 1'b0, addr: PORT_DATA, data: '0};
        case (step)
            ST_SEL_A: begin
                op.wr = 1'b1; op.addr = PORT_DATA; op.data = rg;
            end
            ST_SEL_FN: begin
                op.wr = 1'b1; op.timed = 1'b1; op.addr = PORT_CTRL;
                op.data = ctrl_word(FN_LATCH, sh);
            end
            ST_DAT_A: begin
                op.wr = 1'b1; op.addr = PORT_DATA; op.data = wd;
            end
            ST_DAT_FN: begin
                op.wr = 1'b1; op.timed = 1'b1; op.addr = PORT_CTRL;
                op.data = ctrl_word(FN_WRITE, sh);
            end
            ST_RD_FN: begin
                op.wr = 1'b1; op.timed = 1'b1; op.addr = PORT_CTRL;
                op.data = ctrl_word(FN_READ, sh);
            end
            ST_CFG_IN: begin
                op.wr = 1'b1; op.addr = PORT_CFG; op.data = CFG_DATA_IN;
            end
            ST_CFG_OUT: begin
                op.wr = 1'b1; op.addr = PORT_CFG; op.data = CFG_DATA_OUT;
            end
            ST_RD_CAP: begin
                op.rd = 1'b1; op.addr = PORT_DATA;
            end
            ST_SEL_OFF, ST_DAT_OFF, ST_CFG_IN_C, ST_RD_OFF, ST_CFG_OUT_C: begin
                op.wr = 1'b1; op.addr = PORT_CTRL;
                op.data = ctrl_word(FN_IDLE, sh);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sndbus_seq.sv
module sndbus_seq
    import sndbus_pkg::*;
#(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] hold_len,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_reg,
    input  logic [7:0]        req_wdata,
    input  logic [5:0]        ctl_shadow,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rd_data,
    output logic              pp_wr,
    output logic              pp_rd,
    output logic [1:0]        pp_addr,
    output logic [7:0]        pp_wdata,
    input  logic [7:0]        pp_rdata
);

    localparam seq_state_t SEQ_RESET = '{
        step: ST_IDLE, is_wr: 1'b0, rg: '0, wd: '0, sh: '0, rdat: '0, done: 1'b0
    };

    seq_state_t cur_q, nxt_d;
    port_op_t   op;
    logic       hold_first, hold_done;

    sndbus_step_decode i_decode (
        .step (cur_q.step),
        .rg   (cur_q.rg),
        .wd   (cur_q.wd),
        .sh   (cur_q.sh),
        .op   (op)
    );

    sndbus_hold_timer #(.W(HOLD_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (op.timed),
        .limit   (hold_len),
        .first   (hold_first),
        .expired (hold_done)
    );

    // a timed function is written once, then held
    assign pp_wr    = op.wr & (~op.timed | hold_first);
    assign pp_rd    = op.rd;
    assign pp_addr  = op.addr;
    assign pp_wdata = op.data;

    assign busy    = (cur_q.step != ST_IDLE);
    assign done    = cur_q.done;
    assign rd_data = cur_q.rdat;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        case (cur_q.step)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.step  = ST_SEL_A;
                    nxt_d.is_wr = req_write;
                    nxt_d.rg    = req_reg;
                    nxt_d.wd    = req_wdata;
                    nxt_d.sh    = ctl_shadow;
                end
            end
            ST_SEL_A:    nxt_d.step = ST_SEL_FN;
            ST_SEL_FN:   if (hold_done) nxt_d.step = ST_SEL_OFF;
            ST_SEL_OFF:  nxt_d.step = cur_q.is_wr ? ST_DAT_A : ST_CFG_IN;
            ST_DAT_A:    nxt_d.step = ST_DAT_FN;
            ST_DAT_FN:   if (hold_done) nxt_d.step = ST_DAT_OFF;
            ST_DAT_OFF: begin
                nxt_d.step = ST_IDLE;
                nxt_d.done = 1'b1;
            end
            ST_CFG_IN:   nxt_d.step = ST_CFG_IN_C;
            ST_CFG_IN_C: nxt_d.step = ST_RD_FN;
            ST_RD_FN:    if (hold_done) nxt_d.step = ST_RD_CAP;
            ST_RD_CAP: begin
                nxt_d.rdat = pp_rdata;
                nxt_d.step = ST_RD_OFF;
            end
            ST_RD_OFF:   nxt_d.step = ST_CFG_OUT;
            ST_CFG_OUT:  nxt_d.step = ST_CFG_OUT_C;
            ST_CFG_OUT_C: begin
                nxt_d.step = ST_IDLE;
                nxt_d.done = 1'b1;
            end
            default:     nxt_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= SEQ_RESET;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/sndbus_seq_chk.sv
module sndbus_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [5:0] ctl_shadow,
    input logic       busy,
    input logic       done,
    input logic       pp_wr,
    input logic       pp_rd,
    input logic [1:0] pp_addr,
    input logic [7:0] pp_wdata
);

    logic [5:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  sh_q <= '0;
        else if (req_valid && !busy) sh_q <= ctl_shadow;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pp_wr && !pp_rd));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_end_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_shadow_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_wr && pp_addr == 2'd2) |-> (pp_wdata[5:0] == sh_q));

    p_cfg_rewrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_wr && pp_addr == 2'd3) |=> (pp_wr && pp_addr == 2'd2));

    p_rd_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pp_rd |-> (!pp_wr && pp_addr == 2'd0));

    p_cfg_value_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_wr && pp_addr == 2'd3) |-> (pp_wdata == 8'h82 || pp_wdata == 8'h92));

endmodule

bind sndbus_seq sndbus_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ctl_shadow (ctl_shadow),
    .busy       (busy),
    .done       (done),
    .pp_wr      (pp_wr),
    .pp_rd      (pp_rd),
    .pp_addr    (pp_addr),
    .pp_wdata   (pp_wdata)
);

// File: tb/test_sndbus_seq.sv
`timescale 1ns/1ps
module test_sndbus_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] hold_sel;
    logic       req_valid, req_write;
    logic [7:0] req_reg, req_wdata;
    logic [5:0] ctl_shadow;
    logic       busy, done, pp_wr, pp_rd;
    logic [7:0] rd_data, pp_wdata, pp_rdata;
    logic [1:0] pp_addr;

    always #2.5 clk = ~clk;

    sndbus_seq #(.HOLD_W(4)) i_sndbus_seq (
        .clk(clk), .rst_n(rst_n), .hold_len(hold_sel),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
        .req_wdata(req_wdata), .ctl_shadow(ctl_shadow),
        .busy(busy), .done(done), .rd_data(rd_data),
        .pp_wr(pp_wr), .pp_rd(pp_rd), .pp_addr(pp_addr),
        .pp_wdata(pp_wdata), .pp_rdata(pp_rdata)
    );

    int n_chk = 0, n_fail = 0, n_issued = 0, n_done = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] kbv(input logic [3:0] row);
        return {~row, row};
    endfunction

    // ---------------- parallel port + sound chip model ----------------
    logic [7:0] pa_l, pc_l, cfg_l;
    logic [3:0] chip_sel;
    logic [7:0] chip_regs [16];

    always @(posedge clk) begin
        if (!rst_n) begin
            pa_l <= 8'h00; pc_l <= 8'h00; cfg_l <= 8'h82; chip_sel <= 4'h0;
            for (int i = 0; i < 16; i++) chip_regs[i] <= 8'h00;
        end else begin
            if (pp_wr) begin
                case (pp_addr)
                    2'd0: pa_l <= pp_wdata;
                    2'd2: pc_l <= pp_wdata;
                    2'd3: if (pp_wdata[7]) begin
                        cfg_l <= pp_wdata; pa_l <= 8'h00; pc_l <= 8'h00;
                    end
                    default: ;
                endcase
            end
            if (!cfg_l[4] && pc_l[7:6] == 2'b11) chip_sel <= pa_l[3:0];
            if (!cfg_l[4] && pc_l[7:6] == 2'b10) chip_regs[chip_sel] <= pa_l;
        end
    end

    always_comb begin
        if (cfg_l[4] && pc_l[7:6] == 2'b01)
            pp_rdata = (chip_sel == 4'hE) ? kbv(pc_l[3:0]) : chip_regs[chip_sel];
        else if (cfg_l[4])
            pp_rdata = 8'hFF;
        else
            pp_rdata = pa_l;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         is_wr;
        logic [7:0] rg;
        logic [7:0] wd;
        logic [7:0] exp_rd;
        logic [5:0] sh;
    } item_t;

    item_t      sb[$];
    logic [9:0] wlog[$];
    logic [9:0] eseq[$];
    logic [7:0] exp_regs [16];
    logic [7:0] last_rd = 8'h00;
    logic [1:0] prev_fn = 2'b00;
    int         run_len = 0;
    bit         prev_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pp_wr) wlog.push_back({pp_addr, pp_wdata});
            if (pp_rd)
                chk(!pp_wr && pp_addr == 2'd0 && pc_l[7:6] == 2'b01 && cfg_l == 8'h92,
                    "R11 read strobe context", {pp_wr, pp_addr, pc_l[7:6], cfg_l}, 32'h00192);
            // function hold length and return to idle
            if (pc_l[7:6] != prev_fn) begin
                if (prev_fn != 2'b00) begin
                    chk(run_len == ((prev_fn == 2'b01) ? int'(hold_sel) + 2 : int'(hold_sel) + 1),
                        "R8 function hold length", run_len,
                        (prev_fn == 2'b01) ? int'(hold_sel) + 2 : int'(hold_sel) + 1);
                    chk(pc_l[7:6] == 2'b00, "R8 active function returns to idle", pc_l[7:6], 0);
                end
                prev_fn = pc_l[7:6];
                run_len = 1;
            end else begin
                run_len++;
            end
            if (done) begin
                item_t it;
                bit    ok;
                n_done++;
                chk(!prev_done, "R2 done single pulse", prev_done, 0);
                chk(!busy, "R2 busy low at done", busy, 0);
                if (sb.size() == 0) begin
                    chk(0, "R3 done without accepted request", 1, 0);
                end else begin
                    it = sb.pop_front();
                    eseq.delete();
                    eseq.push_back({2'd0, it.rg});
                    eseq.push_back({2'd2, 2'b11, it.sh});
                    eseq.push_back({2'd2, 2'b00, it.sh});
                    if (it.is_wr) begin
                        eseq.push_back({2'd0, it.wd});
                        eseq.push_back({2'd2, 2'b10, it.sh});
                        eseq.push_back({2'd2, 2'b00, it.sh});
                    end else begin
                        eseq.push_back({2'd3, 8'h92});
                        eseq.push_back({2'd2, 2'b00, it.sh});
                        eseq.push_back({2'd2, 2'b01, it.sh});
                        eseq.push_back({2'd2, 2'b00, it.sh});
                        eseq.push_back({2'd3, 8'h82});
                        eseq.push_back({2'd2, 2'b00, it.sh});
                    end
                    ok = (wlog.size() == eseq.size());
                    for (int i = 0; i < eseq.size(); i++)
                        if (ok && wlog[i] != eseq[i]) ok = 0;
                    chk(ok, it.is_wr ? "R4 write port sequence" : "R5 read port sequence",
                        wlog.size(), eseq.size());
                    if (it.is_wr) begin
                        chk(chip_regs[it.rg[3:0]] == it.wd, "R4 chip register written",
                            chip_regs[it.rg[3:0]], it.wd);
                        chk(rd_data == last_rd, "R9 write leaves read data", rd_data, last_rd);
                    end else begin
                        chk(rd_data == it.exp_rd,
                            (it.rg == 8'h0E) ? "R12 keyboard row read" : "R9 read data",
                            rd_data, it.exp_rd);
                    end
                    chk(pc_l == {2'b00, it.sh}, "R6 R10 port C latch at done", pc_l, {2'b00, it.sh});
                    chk(cfg_l == 8'h82, "R10 output configuration at done", cfg_l, 8'h82);
                end
                last_rd = rd_data;
                wlog.delete();
            end
        end
        prev_done = done;
    end

    // ---------------- driver ----------------
    task automatic do_req(input bit wr, input logic [7:0] rg, input logic [7:0] wd,
                          input logic [5:0] sh, input bit intrude);
        item_t it;
        int    cnt;
        int    exp_len;
        req_valid = 1'b1; req_write = wr; req_reg = rg; req_wdata = wd; ctl_shadow = sh;
        it.is_wr  = wr; it.rg = rg; it.wd = wd; it.sh = sh;
        it.exp_rd = wr ? 8'h00 : ((rg[3:0] == 4'hE) ? kbv(sh[3:0]) : exp_regs[rg[3:0]]);
        if (wr) exp_regs[rg[3:0]] = wd;
        sb.push_back(it);
        n_issued++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        cnt = 0;
        while (busy) begin
            cnt++;
            if (intrude && cnt == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_reg = 8'h06;
                req_wdata = 8'h77; ctl_shadow = 6'h3F;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        exp_len = wr ? 2 * int'(hold_sel) + 6 : 2 * int'(hold_sel) + 10;
        chk(cnt == exp_len, "R2 R8 busy length", cnt, exp_len);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_regs[i] = 8'h00;
        rst_n = 1'b0; hold_sel = 4'd2; req_valid = 1'b0; req_write = 1'b0;
        req_reg = 8'h00; req_wdata = 8'h00; ctl_shadow = 6'h00;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !pp_wr && !pp_rd, "R1 outputs in reset",
            {busy, done, pp_wr, pp_rd}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pp_wr && !pp_rd, "R1 outputs idle after reset",
            {busy, done, pp_wr, pp_rd}, 0);

        hold_sel = 4'd2;
        do_req(1, 8'h03, 8'hA5, 6'h25, 0);
        do_req(0, 8'h03, 8'h00, 6'h0A, 0);
        do_req(1, 8'h01, 8'h3C, 6'h30, 0);
        do_req(0, 8'h01, 8'h00, 6'h11, 0);
        do_req(0, 8'h0E, 8'h00, 6'h17, 0);

        hold_sel = 4'd0;
        do_req(1, 8'h02, 8'hFF, 6'h00, 0);
        do_req(0, 8'h02, 8'h00, 6'h3F, 0);
        do_req(1, 8'h02, 8'h00, 6'h2A, 0);
        do_req(0, 8'h02, 8'h00, 6'h15, 0);
        do_req(0, 8'h0E, 8'h00, 6'h0F, 0);

        hold_sel = 4'd5;
        do_req(1, 8'h06, 8'h42, 6'h05, 0);
        do_req(1, 8'h05, 8'h11, 6'h21, 1);   // intruding request while busy
        do_req(0, 8'h06, 8'h00, 6'h09, 0);
        chk(rd_data == 8'h42, "R3 busy request left register unchanged", rd_data, 8'h42);
        do_req(0, 8'h05, 8'h00, 6'h00, 0);
        do_req(0, 8'h0E, 8'h00, 6'h00, 0);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R3 all requests completed", sb.size(), 0);
        chk(n_done == n_issued, "R3 done count", n_done, n_issued);
        chk(!busy && !pp_wr && !pp_rd, "R1 idle at end", {busy, pp_wr, pp_rd}, 0);
        summary();
    end

endmodule